// File: doc/BRIEF.md
# Two-Wire Bus START/STOP Condition Monitor

This block watches the clock and data lines of a two-wire serial bus and reports bus-level framing events. A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. Both lines pass through a synchronizer before any edge is examined. Every event updates a last-event record that holds at most one of two status flags. The same record gives a bus-free indication that a would-be master reads before it tries to claim the bus.

Each event also sets a sticky interrupt flag. The flag stays set until a clear strobe arrives, and an enable masks it onto the interrupt request. A STOP seen while the bus is busy therefore raises the request, so firmware learns when the bus has been released. While the module is disabled, the status flags are held clear and no events are recognised. The edge-detect history follows the lines during that time, so turning the module on never reports an event that did not happen.

Top module: `i2c_cond_mon`

## Requirements
- R1: While rst_ni is low and after its release: start_seen_o=0, stop_seen_o=0, bus_free_o=1, irq_flag_o=0, irq_o=0.
- R2: A START (sda_i 1->0 with scl_i held at 1) sets start_seen_o to 1 and stop_seen_o to 0.
- R3: A STOP (sda_i 0->1 with scl_i held at 1) sets stop_seen_o to 1 and start_seen_o to 0.
- R4: start_seen_o and stop_seen_o are never 1 at the same time.
- R5: bus_free_o is 1 when stop_seen_o is 1 or when both flags are 0, and is 0 when start_seen_o is 1.
- R6: A change of sda_i while scl_i is 0, and any change of scl_i, leaves both flags and irq_flag_o unchanged.
- R7: irq_flag_o is set by every START and every STOP, and stays set until flag_clr_i is sampled high at a clock edge.
- R8: irq_o equals irq_flag_o AND irq_en_i.
- R9: While en_i is 0, both status flags read 0 and line changes are ignored. Enabling the module with sda_i and scl_i steady at any level produces no event.
- R10: If an event and flag_clr_i arrive at the same clock edge, irq_flag_o ends up 1.
- R11: An event driven on sda_i just after clock edge n shows on the status flags after edge n+3, and not after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Module enable |
| scl_i | input | 1 | Bus clock line level, asynchronous |
| sda_i | input | 1 | Bus data line level, asynchronous |
| irq_en_i | input | 1 | Interrupt request mask |
| flag_clr_i | input | 1 | One-cycle strobe that clears the interrupt flag |
| start_seen_o | output | 1 | A START was the most recent event |
| stop_seen_o | output | 1 | A STOP was the most recent event |
| bus_free_o | output | 1 | The bus may be claimed |
| irq_flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The checks assume the two bus lines never change within the same synchronizer window. They also assume en_i does not switch in the cycle that a synchronized data edge arrives. A simultaneous change would make the START/STOP reading depend on which line the synchronizer caught first. The stimulus changes one line at a time and lets several system clocks pass after each change. It toggles en_i only while both lines are steady. With those rules the bench model predicts every event exactly from the pre-change and post-change line levels.

// File: rtl/i2c_mon_pkg.sv
`timescale 1ns/1ps
package i2c_mon_pkg;
  typedef enum logic [1:0] {
    LAST_NONE  = 2'b00,
    LAST_START = 2'b01,
    LAST_STOP  = 2'b10
  } last_ev_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/line_sync.sv
`timescale 1ns/1ps
module line_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cond_detect.sv
`timescale 1ns/1ps
module cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o
);
  logic sda_q;
  logic en_q;

  // history tracks the line at all times, so enabling sees no stale edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b1;
      en_q  <= 1'b0;
    end else begin
      sda_q <= sda_i;
      en_q  <= en_i;
    end
  end

  logic armed;
  assign armed   = en_i & en_q & scl_i;
  assign start_o = armed &  sda_q & ~sda_i;
  assign stop_o  = armed & ~sda_q &  sda_i;
endmodule

// File: rtl/bus_state.sv
`timescale 1ns/1ps
module bus_state
  import i2c_mon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic stop_i,
  output logic start_seen_o,
  output logic stop_seen_o,
  output logic bus_free_o
);
  last_ev_e last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= LAST_NONE;
    else if (!en_i)   last_q <= LAST_NONE;
    else if (start_i) last_q <= LAST_START;
    else if (stop_i)  last_q <= LAST_STOP;
  end

  assign start_seen_o = (last_q == LAST_START);
  assign stop_seen_o  = (last_q == LAST_STOP);
  assign bus_free_o   = (last_q != LAST_START);
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (event_i) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/i2c_cond_mon.sv
`timescale 1ns/1ps
module i2c_cond_mon
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  output logic start_seen_o,
  output logic stop_seen_o,
  output logic bus_free_o,
  output logic irq_flag_o,
  output logic irq_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] lines_s;
  logic             start_det;
  logic             stop_det;

  line_sync #(
    .WIDTH  (LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  cond_detect u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .scl_i  (lines_s[1]),
    .sda_i  (lines_s[0]),
    .start_o(start_det),
    .stop_o (stop_det)
  );

  bus_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .start_seen_o(start_seen_o),
    .stop_seen_o (stop_seen_o),
    .bus_free_o  (bus_free_o)
  );

  irq_ctrl u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .event_i (start_det | stop_det),
    .clr_i   (flag_clr_i),
    .irq_en_i(irq_en_i),
    .flag_o  (irq_flag_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/i2c_cond_mon_chk.sv
`timescale 1ns/1ps
module i2c_cond_mon_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic irq_en_i,
  input logic flag_clr_i,
  input logic start_seen_o,
  input logic stop_seen_o,
  input logic bus_free_o,
  input logic irq_flag_o,
  input logic irq_o
);
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_seen_o && stop_seen_o)); // R4
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_seen_o |-> !bus_free_o); // R5
  AST_FREE_OTHERWISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_seen_o |-> bus_free_o); // R5
  AST_DISABLED_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!start_seen_o && !stop_seen_o)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && irq_flag_o)); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !flag_clr_i) |=> irq_flag_o); // R7
  AST_START_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_seen_o) |-> irq_flag_o); // R2
  AST_STOP_RAISES_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_seen_o) |-> irq_flag_o); // R3
endmodule

bind i2c_cond_mon i2c_cond_mon_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .irq_en_i    (irq_en_i),
  .flag_clr_i  (flag_clr_i),
  .start_seen_o(start_seen_o),
  .stop_seen_o (stop_seen_o),
  .bus_free_o  (bus_free_o),
  .irq_flag_o  (irq_flag_o),
  .irq_o       (irq_o)
);

// File: tb/i2c_cond_mon_tb_top.sv
`timescale 1ns/1ps
module i2c_cond_mon_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, scl = 1'b1, sda = 1'b1, irq_en = 1'b0, clr = 1'b0;
  logic start_seen, stop_seen, bus_free, irq_flag, irq;

  int checks = 0;
  int failures = 0;

  // model state
  logic m_start = 1'b0, m_stop = 1'b0, m_irq = 1'b0;

  always #10 clk = ~clk;

  i2c_cond_mon dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .scl_i       (scl),
    .sda_i       (sda),
    .irq_en_i    (irq_en),
    .flag_clr_i  (clr),
    .start_seen_o(start_seen),
    .stop_seen_o (stop_seen),
    .bus_free_o  (bus_free),
    .irq_flag_o  (irq_flag),
    .irq_o       (irq)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "start_seen", start_seen, m_start);
    chk(tag, "stop_seen",  stop_seen,  m_stop);
    chk(tag, "bus_free",   bus_free,   m_stop | ~m_start);
    chk(tag, "irq_flag",   irq_flag,   m_irq);
    chk((tag == "R7") ? "R8" : tag, "irq", irq, m_irq & irq_en);
    chk("R4", "excl", start_seen & stop_seen, 1'b0);
  endtask

  // change one line, predict, wait, compare
  task automatic toggle(input bit line_is_sda);
    logic ev_start, ev_stop;
    string tag;
    @(negedge clk);
    ev_start = 1'b0;
    ev_stop  = 1'b0;
    if (line_is_sda) begin
      if (en && scl) begin
        ev_start = sda;
        ev_stop  = ~sda;
      end
      sda = ~sda;
    end else begin
      scl = ~scl;
    end
    if (ev_start) begin m_start = 1'b1; m_stop = 1'b0; m_irq = 1'b1; tag = "R2"; end
    else if (ev_stop) begin m_start = 1'b0; m_stop = 1'b1; m_irq = 1'b1; tag = "R3"; end
    else tag = en ? "R6" : "R9";
    repeat (5) @(negedge clk);
    check_all(tag);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_irq = 1'b0;
    @(negedge clk);
    check_all("R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");

    en = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R9");

    // latency: sda falls with scl high
    @(negedge clk);
    sda = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R11", "start_early", start_seen, 1'b0);
    @(negedge clk);
    chk("R11", "start_on_time", start_seen, 1'b1);
    m_start = 1'b1; m_stop = 1'b0; m_irq = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R2");
    pulse_clr();

    // sweep walks all line states; one line changes per step
    for (int k = 0; k < 48; k++) begin
      irq_en = k[2];
      toggle((k % 3) != 0);
      if (k % 5 == 4) pulse_clr();
    end

    // event and clear at the same edge
    @(negedge clk);
    scl = 1'b1;
    repeat (4) @(negedge clk);
    m_irq = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    repeat (3) @(negedge clk);
    m_start = 1'b0; m_stop = 1'b0;
    if (sda) m_start = 1'b1; else m_stop = 1'b1;
    @(negedge clk);
    sda = ~sda;
    @(negedge clk);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_irq = 1'b1;
    chk("R10", "irq_set_wins", irq_flag, 1'b1);
    repeat (2) @(negedge clk);
    check_all("R10");

    // disabled: flags clear, events ignored
    @(negedge clk);
    en = 1'b0;
    m_start = 1'b0; m_stop = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R9");
    toggle(1'b1);
    toggle(1'b1);
    toggle(1'b1);

    // enable with sda low and scl high: no spurious event
    @(negedge clk);
    en = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R9");
    toggle(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule